// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block turns a serial audio stream into parallel samples. It runs on the bit clock of the link, and its inputs are a frame clock and one data line. A 16-bit mode word selects the channel layout, the word length, the position of the MSB within each slot and the polarity of the frame clock. The supported layouts are two-channel framing (I2S, left-justified and right-justified), TDM framing with 4, 8 or 16 slots of 32 bit clocks, and a packed four-slot layout that uses 16-bit slots.

Each sample that is received comes out as a left-aligned 24-bit word, together with its slot number and a one-cycle valid strobe. If a frame edge arrives before the current frame has delivered all of its slots, the slot count goes back to zero and a sticky error flag is raised. The output side has no ready input. A serial link cannot be paused, so the consumer has to accept each sample in the cycle in which its strobe is high. The mode word must be held stable while frames are running. It is changed only while the block is held in reset.

Top module: `sai_rx_top`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `smp_valid` and `frame_err` are 0.
- R2: Frame start is taken from the edge of the frame clock. With MSB field code 000 (mode bits 4:2) a frame starts on the falling edge; with every other code it starts on the rising edge. Mode bit 8 set to 1 swaps these edges. Bit position 0 of slot 0 is the cycle in which the new level is first sampled.
- R3: The MSB of each slot is taken a number of bit clocks after the start of the slot. That delay is 1 for MSB code 000 (I2S), 0 for code 001 (left-justified), and equal to the code value for codes 011 to 111.
- R4: MSB code 010 (right-justified) places the MSB at the slot length minus the word length. In a 32-clock slot this gives 8 clocks for 24-bit data, 12 for 20-bit, 14 for 18-bit and 16 for 16-bit.
- R5: The word-length field (mode bits 1:0) selects 24 bits with code 00, 20 bits with 01, 16 bits with 10 and 18 bits with 11. Data bits past the word length are ignored. The sample is left-aligned in 24 bits and its unused low bits are 0.
- R6: The layout field (mode bits 6:5) selects 2, 4, 8 or 16 slots for codes 00, 01, 10 and 11. Each slot is 32 bit clocks long, and `smp_chan` gives the slot number counted from 0.
- R7: Mode bit 7 selects the packed layout, which has four slots of 16 bit clocks and ignores the layout field. If the word does not fit in the slot after the MSB delay, it is cut to the bits that do fit.
- R8: `smp_valid` is high for exactly one cycle per slot. It rises in the cycle after the rising edge that captures the last data bit of the slot, and `smp_data` and `smp_chan` are valid in that same cycle.
- R9: If a frame edge arrives while a frame is still incomplete, slot counting restarts at channel 0 and `frame_err` goes to 1 in the next cycle. The flag then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clk | input | 1 | Frame clock from the link |
| sdata | input | 1 | Serial data, MSB first |
| mode | input | 16 | Mode word; bits 15:9 are reserved |
| smp_valid | output | 1 | One-cycle strobe for a received sample |
| smp_data | output | 24 | Left-aligned sample |
| smp_chan | output | 4 | Slot number of the sample |
| frame_err | output | 1 | Sticky flag for an early frame edge |

## Verification
A sample is reported one cycle after the rising edge that captures the last bit of its slot. A framing error is reported one cycle after the rising edge that samples the early frame edge. The bench drives one bit in each falling-edge half period and builds its expected stream with the same cycle index as the drive. It then compares the outputs at the following falling edge against the entry for the cycle that was just clocked. This makes every output comparison exactly one register stage behind the bit that causes it, in every cycle, including the cycles in which no strobe is expected.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;
  localparam int SMP_W  = 24;
  localparam int MODE_W = 16;
  localparam int POS_W  = 6;
  localparam int CH_W   = 4;

  typedef struct packed {
    logic [POS_W-1:0] slot_last;
    logic [CH_W-1:0]  chan_last;
    logic [POS_W-1:0] msb_pos;
    logic [POS_W-1:0] word_len;
    logic             edge_inv;
  } rx_cfg_t;
endpackage

// File: rtl/sai_rx_cfg.sv
module sai_rx_cfg
  import sai_rx_pkg::*;
#(
  parameter int WIDE_SLOT = 32,
  parameter int PACK_SLOT = 16
) (
  input  logic [MODE_W-1:0] mode,
  output rx_cfg_t           cfg
);
  logic [1:0]       wl_code;
  logic [2:0]       align;
  logic [1:0]       layout;
  logic             packed_sel;
  logic             pol_swap;
  logic [POS_W-1:0] slen, wl_raw, dly, room;
  logic             mode_unused;

  assign wl_code     = mode[1:0];
  assign align       = mode[4:2];
  assign layout      = mode[6:5];
  assign packed_sel  = mode[7];
  assign pol_swap    = mode[8];
  assign mode_unused = ^mode[MODE_W-1:9];

  always_comb begin
    slen = packed_sel ? POS_W'(PACK_SLOT) : POS_W'(WIDE_SLOT);
    case (wl_code)
      2'b00:   wl_raw = POS_W'(24);
      2'b01:   wl_raw = POS_W'(20);
      2'b10:   wl_raw = POS_W'(16);
      default: wl_raw = POS_W'(18);
    endcase
    case (align)
      3'd0:    dly = POS_W'(1);
      3'd1:    dly = '0;
      3'd2:    dly = (slen > wl_raw) ? slen - wl_raw : '0;
      default: dly = POS_W'(align);
    endcase
    room = slen - dly;
    cfg.slot_last = slen - POS_W'(1);
    cfg.msb_pos   = dly;
    cfg.word_len  = (wl_raw > room) ? room : wl_raw;
    cfg.edge_inv  = (align == 3'd0) ^ pol_swap;
    if (packed_sel) cfg.chan_last = CH_W'(3);
    else begin
      case (layout)
        2'b00:   cfg.chan_last = CH_W'(1);
        2'b01:   cfg.chan_last = CH_W'(3);
        2'b10:   cfg.chan_last = CH_W'(7);
        default: cfg.chan_last = CH_W'(15);
      endcase
    end
  end
endmodule

// File: rtl/sai_rx_edge.sv
module sai_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fs,
  input  logic inv,
  output logic start
);
  logic lvl, prev_q;

  assign lvl   = fs ^ inv;
  assign start = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R2
endmodule

// File: rtl/sai_rx_timer.sv
module sai_rx_timer
  import sai_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [POS_W-1:0] slot_last,
  input  logic [CH_W-1:0]  chan_last,
  output logic             in_frame,
  output logic [POS_W-1:0] cur_pos,
  output logic [CH_W-1:0]  cur_slot,
  output logic             overrun
);
  logic [POS_W-1:0] pos_q;
  logic [CH_W-1:0]  slot_q;
  logic             act_q;

  assign in_frame = start | act_q;
  assign cur_pos  = start ? '0 : pos_q;
  assign cur_slot = start ? '0 : slot_q;
  assign overrun  = start & act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      slot_q <= '0;
      act_q  <= 1'b0;
    end else if (in_frame) begin
      if (cur_pos == slot_last) begin
        pos_q <= '0;
        if (cur_slot == chan_last) begin
          slot_q <= '0;
          act_q  <= 1'b0;
        end else begin
          slot_q <= cur_slot + CH_W'(1);
          act_q  <= 1'b1;
        end
      end else begin
        pos_q  <= cur_pos + POS_W'(1);
        slot_q <= cur_slot;
        act_q  <= 1'b1;
      end
    end else begin
      act_q <= 1'b0;
    end
  end

  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pos_q == POS_W'(1) && slot_q == '0 && act_q)); // R9
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (slot_q <= chan_last)); // R6
endmodule

// File: rtl/sai_rx_capture.sv
module sai_rx_capture
  import sai_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_frame,
  input  logic [POS_W-1:0] cur_pos,
  input  logic [CH_W-1:0]  cur_slot,
  input  logic             sd,
  input  logic [POS_W-1:0] msb_pos,
  input  logic [POS_W-1:0] word_len,
  output logic             valid,
  output logic [SMP_W-1:0] data,
  output logic [CH_W-1:0]  chan
);
  logic [SMP_W-1:0] acc_q, acc_nx;
  logic [POS_W-1:0] k;
  logic             in_word, last_bit;

  assign k        = cur_pos - msb_pos;
  assign in_word  = in_frame && (cur_pos >= msb_pos) && (cur_pos < msb_pos + word_len);
  assign last_bit = in_word && (cur_pos == msb_pos + word_len - POS_W'(1));

  always_comb begin
    acc_nx = (in_frame && cur_pos == '0) ? '0 : acc_q;
    for (int i = 0; i < SMP_W; i++) begin
      if (in_word && (POS_W'(SMP_W - 1 - i) == k)) acc_nx[i] = sd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      valid <= 1'b0;
      data  <= '0;
      chan  <= '0;
    end else begin
      acc_q <= acc_nx;
      valid <= last_bit;
      if (last_bit) begin
        data <= acc_nx;
        chan <= cur_slot;
      end
    end
  end

  AST_ONE_CYCLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R8
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (SMP_W'(data << word_len) == '0)); // R5
endmodule

// File: rtl/sai_rx_top.sv
module sai_rx_top
  import sai_rx_pkg::*;
#(
  parameter int WIDE_SLOT = 32,
  parameter int PACK_SLOT = 16
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              frame_clk,
  input  logic              sdata,
  input  logic [MODE_W-1:0] mode,
  output logic              smp_valid,
  output logic [SMP_W-1:0]  smp_data,
  output logic [CH_W-1:0]   smp_chan,
  output logic              frame_err
);
  rx_cfg_t          cfg;
  logic             start, in_frame, overrun;
  logic [POS_W-1:0] cur_pos;
  logic [CH_W-1:0]  cur_slot;

  sai_rx_cfg #(.WIDE_SLOT(WIDE_SLOT), .PACK_SLOT(PACK_SLOT)) u_cfg (
    .mode(mode), .cfg(cfg));

  sai_rx_edge u_edge (
    .clk(bclk), .rst_n(rst_n), .fs(frame_clk), .inv(cfg.edge_inv), .start(start));

  sai_rx_timer u_timer (
    .clk(bclk), .rst_n(rst_n), .start(start),
    .slot_last(cfg.slot_last), .chan_last(cfg.chan_last),
    .in_frame(in_frame), .cur_pos(cur_pos), .cur_slot(cur_slot), .overrun(overrun));

  sai_rx_capture u_cap (
    .clk(bclk), .rst_n(rst_n), .in_frame(in_frame), .cur_pos(cur_pos),
    .cur_slot(cur_slot), .sd(sdata), .msb_pos(cfg.msb_pos), .word_len(cfg.word_len),
    .valid(smp_valid), .data(smp_data), .chan(smp_chan));

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n)       frame_err <= 1'b0;
    else if (overrun) frame_err <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge bclk) disable iff (!rst_n)
    frame_err |=> frame_err); // R9
  AST_CHAN_RANGE: assert property (@(posedge bclk) disable iff (!rst_n)
    smp_valid |-> (smp_chan <= cfg.chan_last)); // R6
endmodule

// File: tb/sim_sai_rx_top.sv
module sim_sai_rx_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic        sd = 1'b0;
  logic [15:0] mode = '0;
  logic        v;
  logic [23:0] d;
  logic [3:0]  c;
  logic        e;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int L, N, D, W;
  bit inv;
  bit err_state;

  bit          fs_q[$];
  bit          sd_q[$];
  bit          ev_q[$];
  logic [23:0] ed_q[$];
  logic [3:0]  ec_q[$];
  bit          ee_q[$];

  always #(PERIOD/2) clk = ~clk;

  sai_rx_top u0 (.bclk(clk), .rst_n(rst_n), .frame_clk(fs), .sdata(sd), .mode(mode),
    .smp_valid(v), .smp_data(d), .smp_chan(c), .frame_err(e));

  // Behavioural reading of the mode word, from the requirements
  task automatic set_mode(input bit [1:0] wl, input bit [2:0] al, input bit [1:0] lay,
                          input bit pk, input bit pol);
    int raw;
    mode = {7'b0, pol, pk, lay, al, wl};
    L = pk ? 16 : 32;
    N = pk ? 4 : (2 << lay);
    raw = (wl == 0) ? 24 : (wl == 1) ? 20 : (wl == 2) ? 16 : 18;
    if (al == 0) D = 1;
    else if (al == 1) D = 0;
    else if (al == 2) D = (L > raw) ? L - raw : 0;
    else D = al;
    W = (raw > L - D) ? L - D : raw;
    inv = (al == 0) ^ pol;
  endtask

  task automatic push_cycle(input bit f, input bit b, input bit ev,
                            input logic [23:0] ed, input logic [3:0] ec);
    fs_q.push_back(f); sd_q.push_back(b); ev_q.push_back(ev);
    ed_q.push_back(ed); ec_q.push_back(ec); ee_q.push_back(err_state);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) push_cycle(inv, 1'($urandom), 1'b0, '0, '0);
  endtask

  task automatic add_frame(input int keep, input bit early);
    logic [23:0] smp [16];
    logic [23:0] mask;
    mask = 24'((32'hFFFFFF << (24 - W)) & 32'hFFFFFF);
    for (int s = 0; s < 16; s++) smp[s] = 24'($urandom);
    if (early) err_state = 1'b1;
    for (int j = 0; j < keep; j++) begin
      int s = j / L;
      int p = j % L;
      bit lvl = (j < N * L / 2);
      bit b = 1'($urandom);
      if (p >= D && p < D + W) b = smp[s][23 - (p - D)];
      push_cycle(lvl ^ inv, b, (p == D + W - 1), smp[s] & mask, 4'(s));
    end
  endtask

  task automatic check(input int i, input string req);
    checks++;
    if (v !== ev_q[i] || (ev_q[i] && (d !== ed_q[i] || c !== ec_q[i]))) begin
      errors++;
      $display("FAIL %s cycle %0d: valid %b data %h chan %0d, expected valid %b data %h chan %0d",
               req, i, v, d, c, ev_q[i], ed_q[i], ec_q[i]);
    end
    checks++;
    if (e !== ee_q[i]) begin
      errors++;
      $display("FAIL R9 cycle %0d: frame_err %b, expected %b", i, e, ee_q[i]);
    end
  endtask

  task automatic begin_scn();
    fs_q.delete(); sd_q.delete(); ev_q.delete(); ed_q.delete(); ec_q.delete(); ee_q.delete();
    err_state = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; fs = inv;
    @(negedge clk);
    checks++;
    if (v !== 1'b0 || e !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: valid %b err %b, expected 0 0", v, e);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (v !== 1'b0 || e !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: valid %b err %b, expected 0 0", v, e);
    end
    idle(3);
  endtask

  task automatic play(input string req);
    for (int i = 0; i < fs_q.size(); i++) begin
      if (i > 0) check(i - 1, req);
      fs = fs_q[i]; sd = sd_q[i];
      @(negedge clk);
    end
    check(fs_q.size() - 1, req);
  endtask

  task automatic run(input int frames, input string req);
    begin_scn();
    for (int f = 0; f < frames; f++) add_frame(N * L, 1'b0);
    idle(4);
    play(req);
  endtask

  initial begin
    // R2 R3: two-channel I2S, 24-bit, falling-edge start, MSB delayed by one
    set_mode(2'b00, 3'd0, 2'b00, 1'b0, 1'b0); run(3, "R3");
    // R2: I2S with swapped edge
    set_mode(2'b00, 3'd0, 2'b00, 1'b0, 1'b1); run(2, "R2");
    // R5: left-justified 20-bit, trailing bits ignored, low bits zero
    set_mode(2'b01, 3'd1, 2'b00, 1'b0, 1'b0); run(2, "R5");
    // R5: 18-bit words
    set_mode(2'b11, 3'd1, 2'b00, 1'b0, 1'b0); run(2, "R5");
    // R4: right-justified, 24-bit and 18-bit
    set_mode(2'b00, 3'd2, 2'b00, 1'b0, 1'b0); run(2, "R4");
    set_mode(2'b11, 3'd2, 2'b00, 1'b0, 1'b0); run(2, "R4");
    // R6: TDM8 left-justified 24-bit, TDM16 I2S 16-bit
    set_mode(2'b00, 3'd1, 2'b10, 1'b0, 1'b0); run(2, "R6");
    set_mode(2'b10, 3'd0, 2'b11, 1'b0, 1'b0); run(2, "R6");
    // R3: MSB code 5, TDM4 with swapped edge (R2)
    set_mode(2'b01, 3'd5, 2'b01, 1'b0, 1'b1); run(2, "R3");
    // R7: packed, 16-bit left-justified and 24-bit I2S clipped to slot
    set_mode(2'b10, 3'd1, 2'b00, 1'b1, 1'b0); run(3, "R7");
    set_mode(2'b00, 3'd0, 2'b11, 1'b1, 1'b0); run(2, "R7");
    // R9: early frame edge in TDM4, then full frames from channel 0
    set_mode(2'b00, 3'd1, 2'b01, 1'b0, 1'b0);
    begin_scn();
    add_frame(3 * L, 1'b0);
    add_frame(N * L, 1'b1);
    add_frame(N * L, 1'b0);
    idle(4);
    play("R9");
    // R9 R1: reset clears the flag
    begin_scn();
    // R8: strobe and data timing are checked in every scenario above
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule